// File: doc/BRIEF.md
# External 16-bit Bus Controller

This block connects a single-request internal port to a 16-bit external bus. An accepted request becomes one external read or write cycle of byte or halfword size. The cycle has an active-low read strobe, two active-low byte-lane write strobes and a registered address. Requests marked as internal-area are acknowledged without touching the external bus.

One shared output pin has two roles. When the bus mode input is 1 it is an active-low write strobe. When the bus mode input is 0 it carries the core clock divided by 8 or by 4, chosen by a select input. An active-low wait input stretches the cycle that is in progress.

An external master can take the bus through an active-low request and acknowledge pair. The block grants the bus only between cycles. While the bus is granted, the block drops every output enable and holds back new requests. The wait and request inputs each pass through a two-flop synchronizer.

Top module: `ext_bus_ctrl`

## Requirements
- R1: An external halfword read holds ext_rd_no low for exactly two core cycles when no wait is applied. rsp_rdata_o then returns all 16 bits of ext_data_i, sampled in the last strobe cycle.
- R2: An external byte read samples the whole bus but returns only the addressed lane. Address bit 0 = 0 gives {8'h00, data[7:0]}. Address bit 0 = 1 gives {data[15:8], 8'h00}.
- R3: On a write, the lane strobes follow the size and address bit 0. A halfword write drives both ext_bhw_no and ext_blw_no low. A byte write with bit 0 = 0 drives only ext_blw_no low, and a byte write with bit 0 = 1 drives only ext_bhw_no low. During the write strobe, ext_data_oe_o is 1 and ext_data_o equals req_wdata_i unchanged. During reads, both lane strobes stay high and ext_data_oe_o stays 0.
- R4: An internal-area request (req_internal_i = 1) raises req_ready_o on the cycle after acceptance, with rsp_rdata_o = 0. It asserts no strobe and never drives the data bus.
- R5: With bus_mode_i = 1, ext_clkwr_o is low exactly while the write lane strobes are active. It is high during reads, internal-area accesses and idle cycles.
- R6: With bus_mode_i = 0, ext_clkwr_o is the divided core clock. With clk_sel_i = 0 it is high for 4 and low for 4 cycles; with clk_sel_i = 1 it is high for 2 and low for 2.
- R7: While ext_wait_ni is low, the active strobe stays asserted and req_ready_o stays low. Once ext_wait_ni returns high, the cycle completes within a few cycles.
- R8: While ext_hreq_ni is low and the block is idle, ext_hack_no is low, ext_pins_oe_o is 0 and ext_data_oe_o is 0. New requests are not acknowledged during this time. Raising ext_hreq_ni raises ext_hack_no again, and any stalled request then completes.
- R9: A hold request that arrives during a cycle takes effect only after the cycle ends, including its wait states. Until then ext_hack_no stays high and the strobe stays driven.
- R10: req_ready_o is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_mode_i | input | 1 | 1: shared pin is write strobe, 0: divided clock |
| clk_sel_i | input | 1 | Divided clock: 0 = /8, 1 = /4 |
| req_valid_i | input | 1 | Request valid, held until ready |
| req_ready_o | output | 1 | One-cycle completion pulse |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_byte_i | input | 1 | 1 = byte, 0 = halfword |
| req_internal_i | input | 1 | Access targets the internal area |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 16 | Lane-aligned write data |
| rsp_rdata_o | output | 16 | Lane-aligned read data |
| ext_addr_o | output | AW | External address |
| ext_data_o | output | 16 | Data bus output value |
| ext_data_i | input | 16 | Data bus input value |
| ext_data_oe_o | output | 1 | Data bus drive enable |
| ext_pins_oe_o | output | 1 | Drive enable of address, strobes and shared pin |
| ext_rd_no | output | 1 | Read strobe, active low |
| ext_bhw_no | output | 1 | Upper-lane write strobe, active low |
| ext_blw_no | output | 1 | Lower-lane write strobe, active low |
| ext_clkwr_o | output | 1 | Shared pin: divided clock or write strobe |
| ext_wait_ni | input | 1 | Wait request, active low |
| ext_hreq_ni | input | 1 | Hold request, active low |
| ext_hack_no | output | 1 | Hold acknowledge, active low |

## Verification
The assertions rely on three conditions at the inputs:
- req_valid_i, and the request fields with it, stay steady from the moment they are raised until the ready pulse.
- bus_mode_i changes only while the block is idle.
- ext_data_i is stable during each strobe.

The bench keeps to these conditions by changing the request, mode and data inputs only on falling edges between transactions. It drives random traffic with the wait and hold inputs released. It then uses directed sequences that hold the wait input low across a read and raise a hold request in the middle of a stretched cycle.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_DONE = 2'd2,
    ST_HOLD = 2'd3
  } ebc_state_t;

  // keep addressed byte lane, zero the other; halfword passes through
  function automatic logic [15:0] ebc_lane(input logic is_byte, input logic a0,
                                           input logic [15:0] d);
    if (!is_byte) return d;
    return a0 ? {d[15:8], 8'h00} : {8'h00, d[7:0]};
  endfunction
endpackage

// File: rtl/ebc_sync.sv
module ebc_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // inputs are active low: reset to the inactive level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ebc_clkdiv.sv
module ebc_clkdiv #(
  parameter int unsigned DIV_SLOW = 8,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_fast_i,
  output logic div_clk_o
);
  localparam int unsigned CW = $clog2(DIV_SLOW);
  localparam int unsigned FB = $clog2(DIV_FAST) - 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // ratios are powers of two: a counter bit is the divided clock
  assign div_clk_o = sel_fast_i ? cnt_q[FB] : cnt_q[CW-1];
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int unsigned AW       = 24,
  parameter int unsigned BASE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_byte_i,
  input  logic          req_internal_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [15:0]   req_wdata_i,
  input  logic          wait_act_i,
  input  logic          hold_act_i,
  input  logic [15:0]   data_i,
  output logic          ready_o,
  output logic [15:0]   rdata_o,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   wdata_o,
  output logic          rd_no,
  output logic          wr_act_o,
  output logic          bhw_no,
  output logic          blw_no,
  output logic          in_hold_o
);
  localparam int unsigned CW = $clog2(BASE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(BASE_CYC - 1);

  ebc_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q, byte_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (hold_act_i) begin
            st_q <= ST_HOLD;        // grant only at a cycle boundary
          end else if (req_valid_i) begin
            wr_q    <= req_write_i;
            byte_q  <= req_byte_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            cnt_q   <= '0;
            if (req_internal_i) begin
              rdata_q <= '0;
              st_q    <= ST_DONE;
            end else begin
              st_q <= ST_ACC;
            end
          end
        end
        ST_ACC: begin
          if (cnt_q >= LAST && !wait_act_i) begin
            if (!wr_q) rdata_q <= ebc_lane(byte_q, addr_q[0], data_i);
            st_q <= ST_DONE;
          end else if (cnt_q < LAST) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        ST_HOLD: if (!hold_act_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic in_acc;
  assign in_acc    = (st_q == ST_ACC);
  assign wr_act_o  = in_acc && wr_q;
  assign rd_no     = !(in_acc && !wr_q);
  assign bhw_no    = !(wr_act_o && (!byte_q || addr_q[0]));
  assign blw_no    = !(wr_act_o && (!byte_q || !addr_q[0]));
  assign ready_o   = (st_q == ST_DONE);
  assign in_hold_o = (st_q == ST_HOLD);
  assign rdata_o   = rdata_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int unsigned AW       = 24,
  parameter int unsigned BASE_CYC = 2,
  parameter int unsigned DIV_SLOW = 8,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_mode_i,
  input  logic          clk_sel_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_byte_i,
  input  logic          req_internal_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [15:0]   req_wdata_i,
  output logic [15:0]   rsp_rdata_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [15:0]   ext_data_o,
  input  logic [15:0]   ext_data_i,
  output logic          ext_data_oe_o,
  output logic          ext_pins_oe_o,
  output logic          ext_rd_no,
  output logic          ext_bhw_no,
  output logic          ext_blw_no,
  output logic          ext_clkwr_o,
  input  logic          ext_wait_ni,
  input  logic          ext_hreq_ni
  ,output logic         ext_hack_no
);
  logic [1:0] sync_q;
  logic       div_clk, wr_act, in_hold;

  ebc_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ext_hreq_ni, ext_wait_ni}),
    .q_o    (sync_q)
  );

  ebc_clkdiv #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_fast_i (clk_sel_i),
    .div_clk_o  (div_clk)
  );

  ebc_seq #(.AW(AW), .BASE_CYC(BASE_CYC)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_write_i    (req_write_i),
    .req_byte_i     (req_byte_i),
    .req_internal_i (req_internal_i),
    .req_addr_i     (req_addr_i),
    .req_wdata_i    (req_wdata_i),
    .wait_act_i     (!sync_q[0]),
    .hold_act_i     (!sync_q[1]),
    .data_i         (ext_data_i),
    .ready_o        (req_ready_o),
    .rdata_o        (rsp_rdata_o),
    .addr_o         (ext_addr_o),
    .wdata_o        (ext_data_o),
    .rd_no          (ext_rd_no),
    .wr_act_o       (wr_act),
    .bhw_no         (ext_bhw_no),
    .blw_no         (ext_blw_no),
    .in_hold_o      (in_hold)
  );

  assign ext_data_oe_o = wr_act;
  assign ext_pins_oe_o = !in_hold;
  assign ext_hack_no   = !in_hold;
  assign ext_clkwr_o   = bus_mode_i ? !wr_act : div_clk;
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_mode_i,
  input logic req_ready_o,
  input logic ext_data_oe_o,
  input logic ext_pins_oe_o,
  input logic ext_rd_no,
  input logic ext_bhw_no,
  input logic ext_blw_no,
  input logic ext_clkwr_o,
  input logic ext_wait_ni,
  input logic ext_hack_no
);
  // R1: read strobe spans at least two cycles
  a_r1_rd_two_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_rd_no) |=> !ext_rd_no);

  // R3: reads never assert lane strobes or drive data
  a_r3_read_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rd_no |-> (ext_bhw_no && ext_blw_no && !ext_data_oe_o));

  // R5: shared pin stays high during reads in write-strobe mode
  a_r5_wr_high_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_mode_i && !ext_rd_no) |-> ext_clkwr_o);

  // R7: sustained wait blocks completion
  a_r7_wait_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rd_no && !ext_wait_ni && !$past(ext_wait_ni) && !$past(ext_wait_ni, 2))
      |=> !req_ready_o);

  // R8: acknowledged hold releases every pin
  a_r8_hold_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_hack_no |-> (!ext_pins_oe_o && !ext_data_oe_o));

  // R9: hold begins only after a cycle with no strobe
  a_r9_hold_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_hack_no) |-> ($past(ext_rd_no) && $past(ext_bhw_no) && $past(ext_blw_no)));

  // R10: ready is a single-cycle pulse
  a_r10_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);
endmodule

bind ext_bus_ctrl ebc_chk u_chk (.*);

// File: tb/sim_ext_bus_ctrl.sv
`timescale 1ns/1ps
module sim_ext_bus_ctrl;
  import ebc_pkg::*;
  localparam int unsigned AW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_mode = 1'b1, clk_sel = 1'b0;
  logic valid = 1'b0, ready, wr = 1'b0, by = 1'b0, intl = 1'b0;
  logic [AW-1:0] addr = '0, eaddr;
  logic [15:0] wdata = '0, rdata, dout, din = '0;
  logic doe, poe, rd_n, bhw_n, blw_n, clkwr, wait_n = 1'b1, hreq_n = 1'b1, hack_n;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ext_bus_ctrl #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_mode_i(bus_mode), .clk_sel_i(clk_sel),
    .req_valid_i(valid), .req_ready_o(ready), .req_write_i(wr), .req_byte_i(by),
    .req_internal_i(intl), .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rdata),
    .ext_addr_o(eaddr), .ext_data_o(dout), .ext_data_i(din), .ext_data_oe_o(doe),
    .ext_pins_oe_o(poe), .ext_rd_no(rd_n), .ext_bhw_no(bhw_n), .ext_blw_no(blw_n),
    .ext_clkwr_o(clkwr), .ext_wait_ni(wait_n), .ext_hreq_ni(hreq_n), .ext_hack_no(hack_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic b, input logic a0, input logic [15:0] d);
    if (!b) return d;
    return a0 ? {d[15:8], 8'h00} : {8'h00, d[7:0]};
  endfunction

  function automatic logic [1:0] exp_lanes(input logic b, input logic a0);
    if (!b) return 2'b00;             // {bhw_n, blw_n}
    return a0 ? 2'b01 : 2'b10;
  endfunction

  // one full transaction with per-cycle pin checks
  task automatic txn(input logic w, input logic b, input logic in_a,
                     input logic [AW-1:0] a, input logic [15:0] wd, input logic [15:0] bus);
    int strobe = 0, bad = 0, t = 0;
    logic got = 1'b0;
    @(negedge clk);
    wr = w; by = b; intl = in_a; addr = a; wdata = wd; din = bus; valid = 1'b1;
    while (!got && t < 60) begin
      @(negedge clk);
      t++;
      if (!rd_n || !bhw_n || !blw_n) strobe++;
      if (!rd_n && (w || in_a || doe || !bhw_n || !blw_n)) bad++;
      if (w && !in_a && (!bhw_n || !blw_n)) begin
        if ({bhw_n, blw_n} != exp_lanes(b, a[0]) || !doe || dout != wd) bad++;
      end
      if (in_a && (doe || !rd_n || !bhw_n || !blw_n)) bad++;
      if (bus_mode && clkwr != (bhw_n && blw_n)) bad++;
      got = ready;
    end
    valid = 1'b0;
    chk(got, "R10 ready seen", {31'd0, got}, 32'd1);
    chk(strobe == (in_a ? 0 : 2), in_a ? "R4 no strobe" : "R1 strobe length", strobe,
        in_a ? 0 : 2);
    chk(bad == 0, w ? "R3/R5 write pins" : "R3/R5 read pins", bad, 0);
    if (!w) begin
      if (in_a) chk(rdata == 16'h0, "R4 internal rdata", rdata, 0);
      else chk(rdata == exp_rd(b, a[0], bus), b ? "R2 byte lane" : "R1 halfword",
               rdata, exp_rd(b, a[0], bus));
    end
    @(negedge clk);
    chk(!ready, "R10 single pulse", ready, 0);
  endtask

  task automatic div_chk(input logic sel, input int half);
    int run = 0, bad = 0, edges = 0;
    logic prev;
    @(negedge clk);
    bus_mode = 1'b0; clk_sel = sel;
    repeat (10) @(negedge clk);
    prev = clkwr;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      run++;
      if (clkwr != prev) begin
        if (edges > 0 && run != half) bad++;
        edges++;
        run = 0;
        prev = clkwr;
      end
    end
    chk(bad == 0 && edges > 4, "R6 divided clock", bad, 0);
    bus_mode = 1'b1;
  endtask

  initial begin
    int t;
    logic [15:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ready == 0 && rd_n && bhw_n && blw_n && !doe && poe && hack_n,
        "R10 reset state", {ready, rd_n, bhw_n, blw_n, doe, poe, hack_n}, 7'b0111011);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    txn(1'b0, 1'b0, 1'b0, 24'h000100, 16'h0, 16'hA55A);
    txn(1'b0, 1'b1, 1'b0, 24'h000101, 16'h0, 16'h1234);
    txn(1'b0, 1'b1, 1'b0, 24'h000102, 16'h0, 16'h9876);
    txn(1'b1, 1'b0, 1'b0, 24'h000200, 16'hBEEF, 16'h0);
    txn(1'b1, 1'b1, 1'b0, 24'h000201, 16'hC300, 16'h0);
    txn(1'b1, 1'b1, 1'b0, 24'h000202, 16'h003C, 16'h0);
    txn(1'b0, 1'b0, 1'b1, 24'h000300, 16'h0, 16'hFFFF);
    txn(1'b1, 1'b0, 1'b1, 24'h000300, 16'h5555, 16'h0);

    // constrained random traffic
    for (int i = 0; i < 40; i++) begin
      v = 16'($urandom);
      txn(1'($urandom), 1'($urandom), ($urandom % 6) == 0, AW'($urandom), v, 16'($urandom));
    end

    div_chk(1'b0, 4);
    div_chk(1'b1, 2);

    // R7: wait holds the strobe
    @(negedge clk);
    wait_n = 1'b0;
    repeat (3) @(negedge clk);
    wr = 1'b0; by = 1'b0; intl = 1'b0; addr = 24'h10; din = 16'h6C6C; valid = 1'b1;
    repeat (2) @(negedge clk);
    t = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ready || rd_n) t++;
    end
    chk(t == 0, "R7 wait stalls", t, 0);

    // R9: hold requested mid-cycle waits for the cycle
    hreq_n = 1'b0;
    t = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!hack_n || !poe || rd_n) t++;
    end
    chk(t == 0, "R9 no hold mid-cycle", t, 0);
    wait_n = 1'b1;
    t = 0;
    while (!ready && t < 10) begin @(negedge clk); t++; end
    chk(ready, "R7 completes after wait", ready, 1);
    chk(rdata == 16'h6C6C, "R7 read data", rdata, 16'h6C6C);
    valid = 1'b0;

    // R8: hold state
    repeat (4) @(negedge clk);
    chk(!hack_n && !poe && !doe, "R8 hold pins", {hack_n, poe, doe}, 0);
    wr = 1'b1; by = 1'b0; addr = 24'h20; wdata = 16'h4242; valid = 1'b1;
    t = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ready || !bhw_n || !blw_n) t++;
    end
    chk(t == 0, "R8 request stalled", t, 0);
    hreq_n = 1'b1;
    t = 0;
    while (!ready && t < 12) begin @(negedge clk); t++; end
    chk(ready, "R8 stalled request completes", ready, 1);
    chk(hack_n && poe, "R8 hold released", {hack_n, poe}, 2'b11);
    valid = 1'b0;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end
endmodule